// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This unit produces the merged words for the four partial-word instructions that let software reach a 32-bit word at any byte address. Two of them are loads that fill either the upper end or the lower end of a register. The other two are stores that place either the upper end or the lower end of a register into memory. A pipeline stage gives the unit the instruction's 6-bit major opcode, the two low bits of the effective address, the aligned memory word and the current value of the register operand. One clock later the unit returns either a register write with its enable or a memory write with its enable.

For a load, a shifted part of the memory word is merged over a partly kept copy of the register. For a store, a shifted part of the register is merged over a partly kept copy of the memory word. The unit decides each byte lane on its own: the lane takes a byte from the shifted source at an index worked out from the offset, or it keeps its own byte from the other word. This avoids shift amounts of 0 or 32 bits, which would have undefined edges. Bytes are numbered so that byte lane k is bits [8k+7:8k], and the merge follows one fixed byte order. The unit has no endianness input. Address generation, the memory port and read-modify-write sequencing are handled outside this unit.

Top module: `pwm_unaligned_merge`

## Requirements
- R1: Opcodes 0x22 (load-left) and 0x26 (load-right) raise `reg_we` and keep `mem_we` low. Opcodes 0x2A (store-left) and 0x2E (store-right) raise `mem_we` and keep `reg_we` low. Each enable appears one clock after the opcode is presented.
- R2: Every other opcode leaves both enables low and both data outputs zero.
- R3: Load-left with offset o and s = 24-8o returns (mem << s) OR (rt AND the low-s-bit mask). At offset 0, byte 3 is memory byte 0 and bytes 2..0 keep rt.
- R4: Load-right with s = 8o returns (mem >> s) OR (rt AND the low-s-bit mask shifted left by 32-s). At offset 3, byte 0 is memory byte 3 and bytes 3..1 keep rt.
- R5: Store-left with r = 24-8o writes (mem AND the low-r-bit mask shifted left by 32-r) OR (rt >> r). At offset 0, byte 0 is rt byte 3 and bytes 3..1 keep mem.
- R6: Store-right with r = 8o writes (rt << r) OR (mem AND the low-r-bit mask). At offset 3, byte 3 is rt byte 0 and bytes 2..0 keep mem.
- R7: At the full-word offsets the result is a clean copy with no undefined bits. Load-left at offset 3 and load-right at offset 0 return the memory word. Store-left at offset 3 and store-right at offset 0 return rt.
- R8: While `rst` is high at a rising edge, both enables and both data outputs are cleared, whatever the inputs are.
- R9: `reg_data` is zero whenever `reg_we` is low, and `mem_data` is zero whenever `mem_we` is low.
- R10: A new operation can be presented on every clock. Each result belongs to the inputs from exactly one clock earlier, with no stall or interference between neighbouring operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Major opcode of the instruction |
| byte_off | input | 2 | Low two bits of the effective address |
| mem_word | input | 32 | Aligned memory word |
| rt_val | input | 32 | Current value of the register operand |
| reg_we | output | 1 | Register write enable (loads) |
| reg_data | output | 32 | Merged register value |
| mem_we | output | 1 | Memory write enable (stores) |
| mem_data | output | 32 | Merged memory word |

## Verification
The decoder and the byte-lane merge are combinational and feed one output register, so every result is due exactly one rising edge after its inputs. A driver applies each operation on a falling edge and pushes the expected outputs, which are computed from the shift-and-mask formulas with 64-bit arithmetic, into a queue. A monitor wakes 2 ns after every rising edge and pops one entry for comparison. As a result, back-to-back operations are checked in step with that single register stage. The reset check samples while reset is still held with a load opcode applied.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LOAD_HEAD  = 6'h22;
  localparam logic [OPC_W-1:0] OPC_LOAD_TAIL  = 6'h26;
  localparam logic [OPC_W-1:0] OPC_STORE_HEAD = 6'h2A;
  localparam logic [OPC_W-1:0] OPC_STORE_TAIL = 6'h2E;

  // head = upper end of the register, tail = lower end
  typedef enum logic [2:0] {
    MG_NONE       = 3'd0,
    MG_LOAD_HEAD  = 3'd1,
    MG_LOAD_TAIL  = 3'd2,
    MG_STORE_HEAD = 3'd3,
    MG_STORE_TAIL = 3'd4
  } merge_op_e;

  function automatic merge_op_e decode_opc(input logic [OPC_W-1:0] opc);
    merge_op_e op;
    case (opc)
      OPC_LOAD_HEAD:  op = MG_LOAD_HEAD;
      OPC_LOAD_TAIL:  op = MG_LOAD_TAIL;
      OPC_STORE_HEAD: op = MG_STORE_HEAD;
      OPC_STORE_TAIL: op = MG_STORE_TAIL;
      default:        op = MG_NONE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/pwm_opdec.sv
module pwm_opdec
  import pwm_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output merge_op_e        op,
  output logic             is_load,
  output logic             is_store
);

  always_comb begin
    op       = decode_opc(opc);
    is_load  = (op == MG_LOAD_HEAD)  || (op == MG_LOAD_TAIL);
    is_store = (op == MG_STORE_HEAD) || (op == MG_STORE_TAIL);
  end

endmodule

// File: rtl/pwm_lane.sv
// Per-lane source selection: take a byte from the shifted word at sidx,
// or keep this lane's own byte from the preserved word.
module pwm_lane
  import pwm_pkg::*;
#(
  parameter  int LANES = 4,
  parameter  int IDX   = 0,
  localparam int OFF_W = $clog2(LANES)
) (
  input  merge_op_e        op,
  input  logic [OFF_W-1:0] off,
  output logic             take,
  output logic [OFF_W-1:0] sidx
);

  localparam int TOP = LANES - 1;

  int off_i;
  int src_i;

  always_comb begin
    off_i = {{(32-OFF_W){1'b0}}, off};
    take  = 1'b0;
    src_i = IDX;
    case (op)
      MG_LOAD_HEAD: begin
        take  = (IDX >= TOP - off_i);
        src_i = IDX - (TOP - off_i);
      end
      MG_LOAD_TAIL: begin
        take  = (IDX <= TOP - off_i);
        src_i = IDX + off_i;
      end
      MG_STORE_HEAD: begin
        take  = (IDX <= off_i);
        src_i = IDX + TOP - off_i;
      end
      MG_STORE_TAIL: begin
        take  = (IDX >= off_i);
        src_i = IDX - off_i;
      end
      default: begin
        take  = 1'b0;
        src_i = IDX;
      end
    endcase
    if (!take) src_i = IDX;
    sidx = src_i[OFF_W-1:0];
  end

endmodule

// File: rtl/pwm_merge.sv
module pwm_merge
  import pwm_pkg::*;
#(
  parameter  int LANE_W = 8,
  parameter  int LANES  = 4,
  localparam int WORD_W = LANE_W * LANES,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  merge_op_e         op,
  input  logic              is_load,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [WORD_W-1:0] rt_val,
  output logic [WORD_W-1:0] merged
);

  logic [LANES-1:0][LANE_W-1:0] shifted_l;
  logic [LANES-1:0][LANE_W-1:0] kept_l;
  logic [LANES-1:0][LANE_W-1:0] merged_l;
  logic [LANES-1:0]             take_v;
  logic [OFF_W-1:0]             sidx_a [LANES];

  // loads move memory bytes over rt; stores move rt bytes over memory
  assign shifted_l = is_load ? mem_word : rt_val;
  assign kept_l    = is_load ? rt_val   : mem_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pwm_lane #(
      .LANES (LANES),
      .IDX   (g)
    ) u_lane (
      .op   (op),
      .off  (off),
      .take (take_v[g]),
      .sidx (sidx_a[g])
    );
    assign merged_l[g] = take_v[g] ? shifted_l[sidx_a[g]] : kept_l[g];
  end

  assign merged = merged_l;

endmodule

// File: rtl/pwm_unaligned_merge.sv
module pwm_unaligned_merge
  import pwm_pkg::*;
#(
  parameter  int LANE_W = 8,
  parameter  int LANES  = 4,
  localparam int WORD_W = LANE_W * LANES,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [WORD_W-1:0] rt_val,
  output logic              reg_we,
  output logic [WORD_W-1:0] reg_data,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_data
);

  merge_op_e         op;
  logic              is_load;
  logic              is_store;
  logic [WORD_W-1:0] merged;

  pwm_opdec u_dec (
    .opc      (opcode),
    .op       (op),
    .is_load  (is_load),
    .is_store (is_store)
  );

  pwm_merge #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_merge (
    .op       (op),
    .is_load  (is_load),
    .off      (byte_off),
    .mem_word (mem_word),
    .rt_val   (rt_val),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we   <= 1'b0;
      mem_we   <= 1'b0;
      reg_data <= '0;
      mem_data <= '0;
    end else begin
      reg_we   <= is_load;
      mem_we   <= is_store;
      reg_data <= is_load  ? merged : '0;
      mem_data <= is_store ? merged : '0;
    end
  end

endmodule

// File: rtl/pwm_merge_checker.sv
module pwm_merge_checker
  import pwm_pkg::*;
#(
  parameter  int LANE_W = 8,
  parameter  int LANES  = 4,
  localparam int WORD_W = LANE_W * LANES,
  localparam int OFF_W  = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic [OPC_W-1:0]  opcode,
  input logic [OFF_W-1:0]  byte_off,
  input logic [WORD_W-1:0] mem_word,
  input logic [WORD_W-1:0] rt_val,
  input logic              reg_we,
  input logic [WORD_W-1:0] reg_data,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_data
);

  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(LANES - 1);

  logic op_ld, op_st;
  assign op_ld = (opcode == OPC_LOAD_HEAD)  || (opcode == OPC_LOAD_TAIL);
  assign op_st = (opcode == OPC_STORE_HEAD) || (opcode == OPC_STORE_TAIL);

  assert_load_enable_R1: assert property (@(posedge clk) disable iff (rst)
    op_ld |=> (reg_we && !mem_we));

  assert_store_enable_R1: assert property (@(posedge clk) disable iff (rst)
    op_st |=> (mem_we && !reg_we));

  assert_other_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!op_ld && !op_st) |=> (!reg_we && !mem_we && reg_data == '0 && mem_data == '0));

  assert_load_head_off0_R3: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_LOAD_HEAD && byte_off == '0) |=>
      (reg_data == {$past(mem_word[LANE_W-1:0]), $past(rt_val[WORD_W-LANE_W-1:0])}));

  assert_load_tail_offlast_R4: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_LOAD_TAIL && byte_off == OFF_LAST) |=>
      (reg_data == {$past(rt_val[WORD_W-1:LANE_W]), $past(mem_word[WORD_W-1:WORD_W-LANE_W])}));

  assert_store_head_off0_R5: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_STORE_HEAD && byte_off == '0) |=>
      (mem_data == {$past(mem_word[WORD_W-1:LANE_W]), $past(rt_val[WORD_W-1:WORD_W-LANE_W])}));

  assert_store_tail_offlast_R6: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_STORE_TAIL && byte_off == OFF_LAST) |=>
      (mem_data == {$past(rt_val[LANE_W-1:0]), $past(mem_word[WORD_W-LANE_W-1:0])}));

  assert_load_head_full_R7: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_LOAD_HEAD && byte_off == OFF_LAST) |=> (reg_data == $past(mem_word)));

  assert_load_tail_full_R7: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_LOAD_TAIL && byte_off == '0) |=> (reg_data == $past(mem_word)));

  assert_store_head_full_R7: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_STORE_HEAD && byte_off == OFF_LAST) |=> (mem_data == $past(rt_val)));

  assert_store_tail_full_R7: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_STORE_TAIL && byte_off == '0) |=> (mem_data == $past(rt_val)));

  assert_reg_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !reg_we |-> (reg_data == '0));

  assert_mem_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_we |-> (mem_data == '0));

endmodule

bind pwm_unaligned_merge pwm_merge_checker #(
  .LANE_W (LANE_W),
  .LANES  (LANES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opcode   (opcode),
  .byte_off (byte_off),
  .mem_word (mem_word),
  .rt_val   (rt_val),
  .reg_we   (reg_we),
  .reg_data (reg_data),
  .mem_we   (mem_we),
  .mem_data (mem_data)
);

// File: tb/pwm_unaligned_merge_tb_top.sv
`timescale 1ns/1ps
module pwm_unaligned_merge_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic [1:0]  byte_off = '0;
  logic [31:0] mem_word = '0;
  logic [31:0] rt_val = '0;
  logic        reg_we, mem_we;
  logic [31:0] reg_data, mem_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_unaligned_merge dut_i (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .byte_off (byte_off),
    .mem_word (mem_word),
    .rt_val   (rt_val),
    .reg_we   (reg_we),
    .reg_data (reg_data),
    .mem_we   (mem_we),
    .mem_data (mem_data)
  );

  typedef struct {
    logic        rwe;
    logic        mwe;
    logic [31:0] rdat;
    logic [31:0] mdat;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  // expected values straight from the shift-and-mask formulas, in 64 bits
  function automatic exp_t model(input logic [5:0] opc, input logic [1:0] off,
                                 input logic [31:0] mw, input logic [31:0] rv);
    exp_t e;
    logic [63:0] m, r, k;
    int sh;
    m = {32'h0, mw};
    r = {32'h0, rv};
    e.rwe = 1'b0; e.mwe = 1'b0; e.rdat = '0; e.mdat = '0;
    e.tag = "R2 other opcode";
    case (opc)
      6'h22: begin
        sh = 24 - 8 * int'(off);
        k = (64'd1 << sh) - 64'd1;
        e.rwe = 1'b1;
        e.rdat = 32'((m << sh) | (r & k));
        e.tag = (off == 2'd3) ? "R7 R3 load-left" : "R3 load-left";
      end
      6'h26: begin
        sh = 8 * int'(off);
        k = ((64'd1 << sh) - 64'd1) << (32 - sh);
        e.rwe = 1'b1;
        e.rdat = 32'((m >> sh) | (r & k));
        e.tag = (off == 2'd0) ? "R7 R4 load-right" : "R4 load-right";
      end
      6'h2A: begin
        sh = 24 - 8 * int'(off);
        k = ((64'd1 << sh) - 64'd1) << (32 - sh);
        e.mwe = 1'b1;
        e.mdat = 32'((m & k) | (r >> sh));
        e.tag = (off == 2'd3) ? "R7 R5 store-left" : "R5 store-left";
      end
      6'h2E: begin
        sh = 8 * int'(off);
        k = (64'd1 << sh) - 64'd1;
        e.mwe = 1'b1;
        e.mdat = 32'((r << sh) | (m & k));
        e.tag = (off == 2'd0) ? "R7 R6 store-right" : "R6 store-right";
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [5:0] opc, input logic [1:0] off,
                       input logic [31:0] mw, input logic [31:0] rv);
    @(negedge clk);
    opcode = opc; byte_off = off; mem_word = mw; rt_val = rv;
    sb_q.push_back(model(opc, off, mw, rv));
  endtask

  // monitor: results are due one rising edge after the inputs
  always @(posedge clk) begin
    #2;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (reg_we !== e.rwe || mem_we !== e.mwe) begin
        errors++;
        $display("FAIL R1 (%s): enables reg/mem actual %b/%b expected %b/%b",
                 e.tag, reg_we, mem_we, e.rwe, e.mwe);
      end else if (reg_data !== e.rdat || mem_data !== e.mdat) begin
        errors++;
        $display("FAIL %s R9 R10: data reg/mem actual %h/%h expected %h/%h",
                 e.tag, reg_data, mem_data, e.rdat, e.mdat);
      end
    end
  end

  initial begin
    logic [5:0] ops [4];
    logic [5:0] others [6];
    logic [5:0] mix [8];
    ops = '{6'h22, 6'h26, 6'h2A, 6'h2E};
    others = '{6'h00, 6'h20, 6'h23, 6'h2B, 6'h3F, 6'h06};
    mix = '{6'h22, 6'h26, 6'h2A, 6'h2E, 6'h22, 6'h2E, 6'h23, 6'h00};

    // R8: reset wins over a load applied during reset
    opcode = 6'h22; byte_off = 2'd3; mem_word = 32'hCAFEF00D; rt_val = 32'h12345678;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (reg_we !== 1'b0 || mem_we !== 1'b0 || reg_data !== '0 || mem_data !== '0) begin
      errors++;
      $display("FAIL R8: reset outputs actual %b %b %h %h expected 0 0 0 0",
               reg_we, mem_we, reg_data, mem_data);
    end
    opcode = 6'h00;
    rst = 1'b0;

    // R3..R7: every operation at every offset with distinct patterns
    for (int o = 0; o < 4; o++) begin
      for (int p = 0; p < 4; p++) begin
        drive(ops[o], 2'(p), 32'h44332211, 32'hDDCCBBAA);
        drive(ops[o], 2'(p), 32'hFFFFFFFF, 32'h00000000);
        drive(ops[o], 2'(p), 32'h00000000, 32'hFFFFFFFF);
        drive(ops[o], 2'(p), $urandom, $urandom);
      end
    end

    // R2: other opcodes, including neighbours of the four encodings
    for (int i = 0; i < 6; i++)
      drive(others[i], 2'($urandom), $urandom, $urandom);

    // R10: back-to-back mixed stream, one operation per clock
    for (int i = 0; i < 200; i++)
      drive(mix[$urandom % 8], 2'($urandom), $urandom, $urandom);

    drive(6'h00, 2'd0, 32'h0, 32'h0);
    repeat (3) @(posedge clk);
    #3;
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R10: pending results actual %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule